// File: doc/BRIEF.md
# DMA Channel Control and Status Register Unit

This unit is the register file of a single descriptor-driven DMA channel. A word-wide register port lets software program the channel. A write to the control word never lands in a register of its own. Its upper half selects which status flags change, and its lower half supplies their new values. After that update a fixed chain of rules settles the active and dead flags. When the outcome calls for it, the unit sends a one-cycle flush request to the data mover and a one-cycle kick to the command sequencer.

The unit also holds the descriptor command pointer and three condition-select words. The sequencer uses these selects to qualify interrupt, branch and wait decisions. While the channel is active the pointer is locked against writes. An accepted pointer write is forced to 16-byte alignment and raises a one-cycle fetch request. The sequencer itself and the flush handling of the data mover sit outside this unit. They consume the exported status, pointer, selects and pulses.

Top module: `dma_chan_csr`

## Requirements
- R1: After reset, every register reads zero and flush_req_o, kick_o and fetch_o are low.
- R2: A write to the control word (index 0) sets each status bit i in 15:0 from data bit i when data bit 16+i is 1, and leaves it unchanged otherwise. Only run (15), pause (14), flush (13), wake (12) and device status (7:0) can be given a 1 this way. Dead (11), active (10), bit 9 and branch-taken (8) can only be cleared.
- R3: If wake is set after the masked update, active becomes 1.
- R4: If run is set after the masked update, active becomes 1 and dead becomes 0.
- R5: If pause is set after the masked update, active becomes 0, overriding R3 and R4.
- R6: If a control write takes run from 1 to 0, active and dead both become 0.
- R7: If flush is set after the control write, flush_req_o is high for exactly the one cycle after the write, and the stored flush bit reads 0.
- R8: kick_o is high for the one cycle after a control write exactly when the resulting status has active set.
- R9: A write to the command pointer (index 3) is ignored while active is set. Otherwise the value is stored with bits 3:0 forced to zero, and fetch_o pulses for the one cycle after the write.
- R10: The control word and every unmapped index read as zero. bus_rdata is zero when bus_sel is low.
- R11: The interrupt, branch and wait selects (indices 4, 5, 6) store and read back all 32 bits. A direct status write (index 1) stores bits 15:0 verbatim, applies none of R3 to R8, and gives no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| reg_idx | input | 6 | Word index inside the channel window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| status_o | output | 16 | Current status flags |
| cmd_ptr_o | output | 32 | Descriptor command pointer |
| intr_sel_o | output | 32 | Interrupt condition select |
| branch_sel_o | output | 32 | Branch condition select |
| wait_sel_o | output | 32 | Wait condition select |
| flush_req_o | output | 1 | One-cycle flush request |
| kick_o | output | 1 | One-cycle sequencer kick |
| fetch_o | output | 1 | One-cycle descriptor fetch request |

## Verification
Control writes come from a vector table that pairs a preloaded status with a mask/value word. The table covers run alone, wake alone, run with pause, wake against a held pause, the falling edge of run, flush with and without active, device-status-only updates, an all-zero mask, and attempts to force the derived bits. These cases separate the masked merge from each fix-up rule and from the order in which the rules apply. Directed tests then cover the pointer lock while active against acceptance while idle, readback of the selects and of direct status writes, and reads of zero from control and unmapped slots.

// File: rtl/dma_csr_pkg.sv
package dma_csr_pkg;
   localparam int STAT_W    = 16;
   localparam int BIT_RUN   = 15;
   localparam int BIT_PAUSE = 14;
   localparam int BIT_FLUSH = 13;
   localparam int BIT_WAKE  = 12;
   localparam int BIT_DEAD  = 11;
   localparam int BIT_ACT   = 10;
   localparam int BIT_BT    = 8;
   // flags software may set through the control word
   localparam logic [STAT_W-1:0] CTL_SETTABLE = 16'hF0FF;

   localparam int IDX_CTL  = 0;
   localparam int IDX_STAT = 1;
   localparam int IDX_PTR  = 3;
   localparam int IDX_SEL0 = 4;
   localparam int NUM_SEL  = 3;
endpackage

// File: rtl/csr_addr_dec.sv
module csr_addr_dec
   import dma_csr_pkg::*;
#(
   parameter int IDX_W = 6,
   parameter int N_SEL = NUM_SEL
) (
   input  logic             sel_i,
   input  logic             we_i,
   input  logic [IDX_W-1:0] idx_i,
   output logic             wr_ctl_o,
   output logic             wr_stat_o,
   output logic             wr_ptr_o,
   output logic [N_SEL-1:0] wr_sel_o,
   output logic             rd_stat_o,
   output logic             rd_ptr_o,
   output logic [N_SEL-1:0] rd_sel_o
);
   logic wr_en, rd_en;
   logic hit_ctl, hit_stat, hit_ptr;
   logic [N_SEL-1:0] hit_sel;

   assign wr_en    = sel_i & we_i;
   assign rd_en    = sel_i & ~we_i;
   assign hit_ctl  = (idx_i == IDX_W'(IDX_CTL));
   assign hit_stat = (idx_i == IDX_W'(IDX_STAT));
   assign hit_ptr  = (idx_i == IDX_W'(IDX_PTR));

   for (genvar g = 0; g < N_SEL; g++) begin : g_sel_hit
      assign hit_sel[g] = (idx_i == IDX_W'(IDX_SEL0 + g));
   end

   assign wr_ctl_o  = wr_en & hit_ctl;
   assign wr_stat_o = wr_en & hit_stat;
   assign wr_ptr_o  = wr_en & hit_ptr;
   assign wr_sel_o  = {N_SEL{wr_en}} & hit_sel;
   assign rd_stat_o = rd_en & hit_stat;
   assign rd_ptr_o  = rd_en & hit_ptr;
   assign rd_sel_o  = {N_SEL{rd_en}} & hit_sel;
endmodule

// File: rtl/csr_status_unit.sv
module csr_status_unit
   import dma_csr_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_wr_i,
   input  logic              stat_wr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [STAT_W-1:0] status_o,
   output logic              flush_req_o,
   output logic              kick_o
);
   localparam int HALF = DATA_W / 2;

   logic [STAT_W-1:0] st_q, st_d, merged, fixed;
   logic [STAT_W-1:0] sel_mask, new_val;
   logic              flush_hit, flush_q, kick_q;

   assign sel_mask = wdata_i[DATA_W-1:HALF];
   assign new_val  = wdata_i[HALF-1:0] & CTL_SETTABLE;
   assign merged   = (new_val & sel_mask) | (st_q & ~sel_mask);

   // derived-flag rules, applied in a fixed order
   always_comb begin
      fixed = merged;
      if (fixed[BIT_WAKE]) fixed[BIT_ACT] = 1'b1;
      if (fixed[BIT_RUN]) begin
         fixed[BIT_ACT]  = 1'b1;
         fixed[BIT_DEAD] = 1'b0;
      end
      if (fixed[BIT_PAUSE]) fixed[BIT_ACT] = 1'b0;
      if (st_q[BIT_RUN] && !fixed[BIT_RUN]) begin
         fixed[BIT_ACT]  = 1'b0;
         fixed[BIT_DEAD] = 1'b0;
      end
      flush_hit        = fixed[BIT_FLUSH];
      fixed[BIT_FLUSH] = 1'b0;
   end

   always_comb begin
      st_d = st_q;
      if (ctl_wr_i)       st_d = fixed;
      else if (stat_wr_i) st_d = wdata_i[STAT_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= '0;
         flush_q <= 1'b0;
         kick_q  <= 1'b0;
      end else begin
         st_q    <= st_d;
         flush_q <= ctl_wr_i & flush_hit;
         kick_q  <= ctl_wr_i & fixed[BIT_ACT];
      end
   end

   assign status_o    = st_q;
   assign flush_req_o = flush_q;
   assign kick_o      = kick_q;

   AST_PAUSE_BLOCKS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
      $past(ctl_wr_i) && st_q[BIT_PAUSE] |-> !st_q[BIT_ACT]); // R5
   AST_RUN_CLEARS_DEAD: assert property (@(posedge clk) disable iff (!rst_n)
      $past(ctl_wr_i) && st_q[BIT_RUN] |-> !st_q[BIT_DEAD]); // R4
   AST_RUN_FALL_QUIETS: assert property (@(posedge clk) disable iff (!rst_n)
      $past(ctl_wr_i) && $past(st_q[BIT_RUN]) && !st_q[BIT_RUN]
      |-> !st_q[BIT_ACT] && !st_q[BIT_DEAD]); // R6
   AST_FLUSH_SELF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      flush_req_o |-> !st_q[BIT_FLUSH]); // R7
   AST_KICK_NEEDS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
      kick_o |-> st_q[BIT_ACT]); // R8
endmodule

// File: rtl/csr_ptr_unit.sv
module csr_ptr_unit #(
   parameter int DATA_W     = 32,
   parameter int ALIGN_BITS = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_i,
   input  logic                     active_i,
   input  logic [DATA_W-1:ALIGN_BITS] wdata_hi_i,
   output logic [DATA_W-1:0]        ptr_o,
   output logic                     fetch_o
);
   logic [DATA_W-1:ALIGN_BITS] ptr_q;
   logic                       fetch_q;
   logic                       accept;

   assign accept = wr_i & ~active_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr_q   <= '0;
         fetch_q <= 1'b0;
      end else begin
         if (accept) ptr_q <= wdata_hi_i;
         fetch_q <= accept;
      end
   end

   assign ptr_o   = {ptr_q, {ALIGN_BITS{1'b0}}};
   assign fetch_o = fetch_q;

   AST_PTR_LOCKED_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
      active_i |=> $stable(ptr_o)); // R9
   AST_PTR_MOVE_FETCHES: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ptr_o) |-> fetch_o); // R9
endmodule

// File: rtl/csr_sel_bank.sv
module csr_sel_bank #(
   parameter int DATA_W = 32,
   parameter int N_SEL  = 3
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [N_SEL-1:0]             wr_i,
   input  logic [DATA_W-1:0]            wdata_i,
   output logic [N_SEL-1:0][DATA_W-1:0] sel_o
);
   for (genvar g = 0; g < N_SEL; g++) begin : g_sel
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk) begin
         if (!rst_n)     q <= '0;
         else if (wr_i[g]) q <= wdata_i;
      end
      assign sel_o[g] = q;
      AST_SEL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
         !wr_i[g] |=> $stable(sel_o[g])); // R11
   end
endmodule

// File: rtl/dma_chan_csr.sv
module dma_chan_csr
   import dma_csr_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int IDX_W      = 6,
   parameter int ALIGN_BITS = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_we,
   input  logic [IDX_W-1:0]  reg_idx,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic [STAT_W-1:0] status_o,
   output logic [DATA_W-1:0] cmd_ptr_o,
   output logic [DATA_W-1:0] intr_sel_o,
   output logic [DATA_W-1:0] branch_sel_o,
   output logic [DATA_W-1:0] wait_sel_o,
   output logic              flush_req_o,
   output logic              kick_o,
   output logic              fetch_o
);
   if (DATA_W != 2 * STAT_W) begin : g_bad_width
      $error("DATA_W must hold a mask half and a value half of the status");
   end
   if (IDX_W < 3) begin : g_bad_idx
      $error("IDX_W too small to reach the select registers");
   end
   if (ALIGN_BITS < 1 || ALIGN_BITS >= DATA_W) begin : g_bad_align
      $error("ALIGN_BITS out of range");
   end

   logic wr_ctl, wr_stat, wr_ptr, rd_stat, rd_ptr;
   logic [NUM_SEL-1:0] wr_sel, rd_sel;
   logic [NUM_SEL-1:0][DATA_W-1:0] sel_q;
   logic [STAT_W-1:0] st;

   csr_addr_dec #(.IDX_W(IDX_W), .N_SEL(NUM_SEL)) u_dec (
      .sel_i(bus_sel), .we_i(bus_we), .idx_i(reg_idx),
      .wr_ctl_o(wr_ctl), .wr_stat_o(wr_stat), .wr_ptr_o(wr_ptr),
      .wr_sel_o(wr_sel), .rd_stat_o(rd_stat), .rd_ptr_o(rd_ptr),
      .rd_sel_o(rd_sel)
   );

   csr_status_unit #(.DATA_W(DATA_W)) u_stat (
      .clk(clk), .rst_n(rst_n), .ctl_wr_i(wr_ctl), .stat_wr_i(wr_stat),
      .wdata_i(bus_wdata), .status_o(st),
      .flush_req_o(flush_req_o), .kick_o(kick_o)
   );

   csr_ptr_unit #(.DATA_W(DATA_W), .ALIGN_BITS(ALIGN_BITS)) u_ptr (
      .clk(clk), .rst_n(rst_n), .wr_i(wr_ptr), .active_i(st[BIT_ACT]),
      .wdata_hi_i(bus_wdata[DATA_W-1:ALIGN_BITS]),
      .ptr_o(cmd_ptr_o), .fetch_o(fetch_o)
   );

   csr_sel_bank #(.DATA_W(DATA_W), .N_SEL(NUM_SEL)) u_sel (
      .clk(clk), .rst_n(rst_n), .wr_i(wr_sel), .wdata_i(bus_wdata),
      .sel_o(sel_q)
   );

   // control and unmapped slots contribute nothing, so they read zero
   always_comb begin
      bus_rdata = '0;
      if (rd_stat) bus_rdata = bus_rdata | {{(DATA_W-STAT_W){1'b0}}, st};
      if (rd_ptr)  bus_rdata = bus_rdata | cmd_ptr_o;
      for (int i = 0; i < NUM_SEL; i++) begin
         if (rd_sel[i]) bus_rdata = bus_rdata | sel_q[i];
      end
   end

   assign status_o     = st;
   assign intr_sel_o   = sel_q[0];
   assign branch_sel_o = sel_q[1];
   assign wait_sel_o   = sel_q[2];

   AST_NO_PULSE_IN_RESET: assert property (@(posedge clk)
      !rst_n |=> !kick_o && !flush_req_o && !fetch_o); // R1
   AST_CTL_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      bus_sel && !bus_we && reg_idx == IDX_W'(IDX_CTL) |-> bus_rdata == '0); // R10
endmodule

// File: tb/dma_chan_csr_tb_top.sv
`timescale 1ns/1ps
module dma_chan_csr_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_we = 1'b0;
   logic [5:0]  reg_idx = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata, cmd_ptr_o, intr_sel_o, branch_sel_o, wait_sel_o;
   logic [15:0] status_o;
   logic        flush_req_o, kick_o, fetch_o;
   int n_chk = 0, n_fail = 0;

   always #2 clk = ~clk;

   dma_chan_csr dut_i (.*);

   // {preset status, control word, expected status, flush, kick}
   localparam int NV = 17;
   localparam logic [65:0] VEC [NV] = '{
      {16'h0000, 32'h8000_8000, 16'h8400, 1'b0, 1'b1}, // R4 run
      {16'h0800, 32'h8000_8000, 16'h8400, 1'b0, 1'b1}, // R4 run clears dead
      {16'h0000, 32'h1000_1000, 16'h1400, 1'b0, 1'b1}, // R3 wake
      {16'h0000, 32'hC000_C000, 16'hC000, 1'b0, 1'b0}, // R5 pause beats run
      {16'h0800, 32'hC000_C000, 16'hC000, 1'b0, 1'b0}, // R4 R5
      {16'h8C00, 32'h8000_0000, 16'h0000, 1'b0, 1'b0}, // R6 run falls
      {16'h0000, 32'h2000_2000, 16'h0000, 1'b1, 1'b0}, // R7 flush idle
      {16'h0400, 32'h2000_2000, 16'h0400, 1'b1, 1'b1}, // R7 R8 flush active
      {16'h0000, 32'h00FF_00A5, 16'h00A5, 1'b0, 1'b0}, // R2 devstat
      {16'h005A, 32'h000F_0003, 16'h0053, 1'b0, 1'b0}, // R2 partial mask
      {16'h0000, 32'h0000_FFFF, 16'h0000, 1'b0, 1'b0}, // R2 zero mask
      {16'h0000, 32'h0F00_0F00, 16'h0000, 1'b0, 1'b0}, // R2 derived not settable
      {16'h0D00, 32'h0F00_0F00, 16'h0000, 1'b0, 1'b0}, // R2 derived clearable
      {16'h8000, 32'h1000_1000, 16'h9400, 1'b0, 1'b1}, // R3 R8
      {16'h4000, 32'h1000_1000, 16'h5000, 1'b0, 1'b0}, // R5 pause beats wake
      {16'h0C00, 32'h8000_0000, 16'h0C00, 1'b0, 1'b1}, // R6 no edge, R8
      {16'h8400, 32'hA000_2000, 16'h0000, 1'b1, 1'b0}  // R6 R7
   };

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [5:0] idx, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b1; reg_idx = idx; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_we = 1'b0;
   endtask

   task automatic rd(input logic [5:0] idx, output logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b0; reg_idx = idx;
      #1 d = bus_rdata;
      bus_sel = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk); rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired (all requirements)");
      summary();
   end

   initial begin
      logic [31:0] v;
      do_reset();
      // R1 reset state
      check("R1 flush", {31'b0, flush_req_o}, 0);
      check("R1 kick", {31'b0, kick_o}, 0);
      check("R1 fetch", {31'b0, fetch_o}, 0);
      for (int i = 0; i < 8; i++) begin
         rd(6'(i), v); check("R1 reg zero", v, 0);
      end

      for (int k = 0; k < NV; k++) begin
         logic [65:0] t;
         t = VEC[k];
         wr(6'd1, {16'h0, t[65:50]});
         wr(6'd0, t[49:18]);
         check($sformatf("R2-vec%0d flush", k), {31'b0, flush_req_o}, {31'b0, t[1]});
         check($sformatf("R8 vec%0d kick", k), {31'b0, kick_o}, {31'b0, t[0]});
         rd(6'd1, v);
         check($sformatf("R2 vec%0d status", k), v, {16'h0, t[17:2]});
      end

      // R9 pointer accepted while idle
      wr(6'd1, 32'h0);
      wr(6'd3, 32'h1234_567F);
      check("R9 fetch pulse", {31'b0, fetch_o}, 1);
      rd(6'd3, v); check("R9 aligned ptr", v, 32'h1234_5670);
      check("R9 fetch one cycle", {31'b0, fetch_o}, 0);
      // R9 pointer locked while active
      wr(6'd1, 32'h0400);
      wr(6'd3, 32'hAAAA_AAA0);
      check("R9 no fetch active", {31'b0, fetch_o}, 0);
      rd(6'd3, v); check("R9 ptr held", v, 32'h1234_5670);

      // R11 select registers and raw status write
      wr(6'd4, 32'hDEAD_BEEF); wr(6'd5, 32'h0123_4567); wr(6'd6, 32'hFFFF_0001);
      rd(6'd4, v); check("R11 intr sel", v, 32'hDEAD_BEEF);
      rd(6'd5, v); check("R11 branch sel", v, 32'h0123_4567);
      rd(6'd6, v); check("R11 wait sel", v, 32'hFFFF_0001);
      wr(6'd1, 32'hFFFF_9000);
      check("R11 raw status no kick", {31'b0, kick_o}, 0);
      rd(6'd1, v); check("R11 raw status", v, 32'h0000_9000);

      // R10 control and unmapped slots read zero
      wr(6'd2, 32'h5555_5555); wr(6'd7, 32'h5555_5555); wr(6'd63, 32'h5555_5555);
      rd(6'd0, v); check("R10 ctl reads zero", v, 0);
      rd(6'd2, v); check("R10 idx2 zero", v, 0);
      rd(6'd7, v); check("R10 idx7 zero", v, 0);
      rd(6'd63, v); check("R10 idx63 zero", v, 0);
      @(negedge clk); bus_sel = 1'b0; bus_we = 1'b0; reg_idx = 6'd4;
      #1 check("R10 idle bus zero", bus_rdata, 0);

      // R1 reset mid-operation
      do_reset();
      rd(6'd1, v); check("R1 status after reset", v, 0);
      rd(6'd3, v); check("R1 ptr after reset", v, 0);
      rd(6'd4, v); check("R1 sel after reset", v, 0);
      summary();
   end
endmodule